// File: doc/BRIEF.md
# Stacked-Layer Stub Coincidence Finder

This block looks for short track segments, here called stubs, in two pixel sensor layers mounted close together and aligned with each other. For each bunch crossing it takes in the hits from the inner layer and the hits from the outer layer as two framed streams. Each hit carries a column address, and inner hits also carry a row address. Because the layers are aligned, a straight, stiff track lights up nearly the same column in both layers. Any inner/outer pair whose column addresses differ by no more than a programmable half-width is reported as a stub. A smaller difference points to a track with higher transverse momentum.

Both hit streams, the stub output and the per-crossing count output are valid/ready interfaces. A beat moves on a rising edge where valid and ready are both high. A source must hold valid and its data steady until that beat is taken. Each layer buffers one crossing. Once a layer has taken its last beat, it drops ready until the count for that crossing has been taken. This back-pressure keeps crossings apart. The stub and count outputs hold their record for as long as the consumer keeps ready low, so a stalled consumer loses nothing. The window register and the two sticky overflow flags are plain pins.

Top module: `stub_finder`

## Requirements
- R1: The window half-width is a 3-bit register, written through `win_we`/`win_wdata`, that resets to 1. The scan of a crossing uses the value the register holds when both layers of that crossing are complete.
- R2: A stub is emitted for an inner/outer pair exactly when |inner column − outer column| ≤ window. `stub_dcol` carries inner column minus outer column in two's complement, COL_W+1 bits wide, and column arithmetic never wraps.
- R3: Each layer keeps the first 16 hits of a crossing. Further hits are accepted and discarded, and they set that layer's overflow flag. The flag stays set until reset.
- R4: Every kept inner hit is paired once with every kept outer hit. Stubs leave in inner-arrival order, and within one inner hit in outer-arrival order. Each stub carries the inner row and the inner column.
- R5: After the last stub of a crossing, one count record gives the number of stubs for that crossing. A count record is also sent when the count is zero, for example when a layer is empty. A beat with both `*_void` and `*_last` high closes a layer without adding a hit.
- R6: Hits of two crossings are never paired. After a layer's last beat, its ready stays low until the count record has been accepted. Ready is high again on the cycle that follows that acceptance.
- R7: While an output's valid is high and its ready is low, valid stays high and the record stays unchanged. No stub and no count is lost under stalls.
- R8: After reset both hit inputs are ready, no output is valid, and both overflow flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_we | input | 1 | Load the window register |
| win_wdata | input | 3 | New window half-width |
| inr_valid | input | 1 | Inner hit beat valid |
| inr_ready | output | 1 | Inner hit beat accepted |
| inr_row | input | ROW_W | Inner hit row |
| inr_col | input | COL_W | Inner hit column |
| inr_last | input | 1 | Last inner beat of the crossing |
| inr_void | input | 1 | Beat carries no hit |
| otr_valid | input | 1 | Outer hit beat valid |
| otr_ready | output | 1 | Outer hit beat accepted |
| otr_col | input | COL_W | Outer hit column |
| otr_last | input | 1 | Last outer beat of the crossing |
| otr_void | input | 1 | Beat carries no hit |
| stub_valid | output | 1 | Stub record valid |
| stub_ready | input | 1 | Stub consumer ready |
| stub_row | output | ROW_W | Inner row of the stub |
| stub_col | output | COL_W | Inner column of the stub |
| stub_dcol | output | COL_W+1 | Signed inner−outer column difference |
| cnt_valid | output | 1 | Count record valid |
| cnt_ready | input | 1 | Count consumer ready |
| cnt_value | output | TALLY_W | Stubs in the crossing |
| ovf_inner | output | 1 | Sticky inner overflow flag |
| ovf_outer | output | 1 | Sticky outer overflow flag |

## Verification
A layer's ready falls on the edge that takes its last beat, so the bench tests it at the next falling edge. Candidate pairs are scanned one per cycle, and a matching pair appears on the stub output on the edge after its scan step. The count record follows at least one cycle after the last stub has been taken. Because all of this latency depends on the data, the bench does not wait a fixed number of cycles. It drives ready at each falling edge, records a transfer whenever it sees valid and ready together at that point, and compares each transfer in order against a list built from R2 and R4. A transfer-count limit catches a missing record, and ready is checked again one falling edge after the count handshake.

// File: rtl/stub_pkg.sv
package stub_pkg;
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_SCAN  = 2'd1,
    SC_FLUSH = 2'd2,
    SC_EMIT  = 2'd3
  } scan_st_t;

  // magnitude of a two's complement column difference
  function automatic logic [15:0] abs_diff16(input logic signed [15:0] d);
    return d[15] ? 16'(-d) : 16'(d);
  endfunction
endpackage

// File: rtl/stub_hit_buf.sv
module stub_hit_buf #(
  parameter int W     = 10,
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [W-1:0]     s_data,
  input  logic             s_last,
  input  logic             s_void,
  input  logic             release_i,
  output logic             done_o,
  output logic [CNT_W-1:0] n_o,
  output logic             ovf_o,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] mem [DEPTH];
  logic         take;
  logic         room;

  assign s_ready = !done_o;
  assign take    = s_valid && s_ready;
  assign room    = (n_o < CNT_W'(DEPTH));
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      n_o    <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (release_i) begin
        done_o <= 1'b0;
        n_o    <= '0;
      end else if (take) begin
        if (!s_void) begin
          if (room) n_o <= n_o + CNT_W'(1);
          else      ovf_o <= 1'b1;
        end
        if (s_last) done_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && !s_void && room) mem[n_o[IDX_W-1:0]] <= s_data;
  end

  // R3: kept hits never exceed the buffer depth
  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    n_o <= CNT_W'(DEPTH)) else $error("hit count above depth");
  // R3: overflow flag is sticky
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o) else $error("overflow flag cleared");
endmodule

// File: rtl/stub_win_cmp.sv
module stub_win_cmp #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] col_a,
  input  logic [COL_W-1:0] col_b,
  input  logic [2:0]       win,
  output logic [COL_W:0]   diff,
  output logic             match
);
  logic [COL_W:0] mag;

  always_comb begin
    diff  = {1'b0, col_a} - {1'b0, col_b};
    mag   = diff[COL_W] ? (~diff + (COL_W+1)'(1)) : diff;
    match = (mag <= {{(COL_W-2){1'b0}}, win});
  end
endmodule

// File: rtl/stub_pair_scan.sv
module stub_pair_scan
  import stub_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 10,
  parameter int DEPTH = 16,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int TALLY_W = $clog2(DEPTH * DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         win,
  input  logic               in_done,
  input  logic               out_done,
  input  logic [CNT_W-1:0]   in_n,
  input  logic [CNT_W-1:0]   out_n,
  output logic [IDX_W-1:0]   in_idx,
  output logic [IDX_W-1:0]   out_idx,
  input  logic [ROW_W-1:0]   in_row,
  input  logic [COL_W-1:0]   in_col,
  input  logic [COL_W-1:0]   out_col,
  output logic               release_o,
  output logic               stub_valid,
  input  logic               stub_ready,
  output logic [ROW_W-1:0]   stub_row,
  output logic [COL_W-1:0]   stub_col,
  output logic [COL_W:0]     stub_dcol,
  output logic               cnt_valid,
  input  logic               cnt_ready,
  output logic [TALLY_W-1:0] cnt_value
);
  scan_st_t           st;
  logic [2:0]         win_q;
  logic [TALLY_W-1:0] tally;
  logic [COL_W:0]     diff;
  logic               hit;
  logic               adv;
  logic               j_end;
  logic               i_end;

  stub_win_cmp #(.COL_W(COL_W)) u_cmp (
    .col_a(in_col), .col_b(out_col), .win(win_q), .diff(diff), .match(hit)
  );

  assign adv       = !stub_valid || stub_ready;
  assign j_end     = (CNT_W'(out_idx) == out_n - CNT_W'(1));
  assign i_end     = (CNT_W'(in_idx) == in_n - CNT_W'(1));
  assign release_o = (st == SC_EMIT) && cnt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SC_IDLE;
      win_q      <= 3'd1;
      tally      <= '0;
      in_idx     <= '0;
      out_idx    <= '0;
      stub_valid <= 1'b0;
      stub_row   <= '0;
      stub_col   <= '0;
      stub_dcol  <= '0;
      cnt_valid  <= 1'b0;
      cnt_value  <= '0;
    end else begin
      unique case (st)
        SC_IDLE: begin
          if (in_done && out_done) begin
            win_q   <= win;
            tally   <= '0;
            in_idx  <= '0;
            out_idx <= '0;
            if (in_n == '0 || out_n == '0) begin
              cnt_valid <= 1'b1;
              cnt_value <= '0;
              st        <= SC_EMIT;
            end else begin
              st <= SC_SCAN;
            end
          end
        end
        SC_SCAN: begin
          if (adv) begin
            stub_valid <= hit;
            if (hit) begin
              stub_row  <= in_row;
              stub_col  <= in_col;
              stub_dcol <= diff;
            end
            tally <= tally + TALLY_W'(hit);
            if (j_end) begin
              out_idx <= '0;
              if (i_end) st <= SC_FLUSH;
              else       in_idx <= in_idx + IDX_W'(1);
            end else begin
              out_idx <= out_idx + IDX_W'(1);
            end
          end
        end
        SC_FLUSH: begin
          if (adv) begin
            stub_valid <= 1'b0;
            cnt_valid  <= 1'b1;
            cnt_value  <= tally;
            st         <= SC_EMIT;
          end
        end
        SC_EMIT: begin
          if (cnt_ready) begin
            cnt_valid <= 1'b0;
            st        <= SC_IDLE;
          end
        end
        default: st <= SC_IDLE;
      endcase
    end
  end

  // R7: stub record held under back-pressure
  p_stub_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stub_valid && !stub_ready |=> stub_valid && $stable({stub_row, stub_col, stub_dcol}))
    else $error("stub changed while stalled");
  // R7: count record held under back-pressure
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid && !cnt_ready |=> cnt_valid && $stable(cnt_value))
    else $error("count changed while stalled");
  // R5: count never overlaps a pending stub
  p_cnt_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stub_valid, cnt_valid})) else $error("stub and count together");
  // R2: every emitted stub lies within the captured window
  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stub_valid |-> abs_diff16(16'(signed'(stub_dcol))) <= 16'(win_q))
    else $error("stub outside window");
endmodule

// File: rtl/stub_finder.sv
module stub_finder #(
  parameter int ROW_W = 8,
  parameter int COL_W = 10,
  parameter int DEPTH = 16,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int TALLY_W = $clog2(DEPTH * DEPTH + 1),
  localparam int IN_W    = ROW_W + COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_we,
  input  logic [2:0]         win_wdata,
  input  logic               inr_valid,
  output logic               inr_ready,
  input  logic [ROW_W-1:0]   inr_row,
  input  logic [COL_W-1:0]   inr_col,
  input  logic               inr_last,
  input  logic               inr_void,
  input  logic               otr_valid,
  output logic               otr_ready,
  input  logic [COL_W-1:0]   otr_col,
  input  logic               otr_last,
  input  logic               otr_void,
  output logic               stub_valid,
  input  logic               stub_ready,
  output logic [ROW_W-1:0]   stub_row,
  output logic [COL_W-1:0]   stub_col,
  output logic [COL_W:0]     stub_dcol,
  output logic               cnt_valid,
  input  logic               cnt_ready,
  output logic [TALLY_W-1:0] cnt_value,
  output logic               ovf_inner,
  output logic               ovf_outer
);
  logic [2:0]       win_reg;
  logic             rel;
  logic             in_done, out_done;
  logic [CNT_W-1:0] in_n, out_n;
  logic [IDX_W-1:0] in_idx, out_idx;
  logic [IN_W-1:0]  in_rd;
  logic [COL_W-1:0] out_rd;

  // R1: window half-width register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_reg <= 3'd1;
    else if (win_we) win_reg <= win_wdata;
  end

  stub_hit_buf #(.W(IN_W), .DEPTH(DEPTH)) u_inner (
    .clk(clk), .rst_n(rst_n),
    .s_valid(inr_valid), .s_ready(inr_ready), .s_data({inr_row, inr_col}),
    .s_last(inr_last), .s_void(inr_void),
    .release_i(rel), .done_o(in_done), .n_o(in_n), .ovf_o(ovf_inner),
    .rd_idx(in_idx), .rd_data(in_rd)
  );

  stub_hit_buf #(.W(COL_W), .DEPTH(DEPTH)) u_outer (
    .clk(clk), .rst_n(rst_n),
    .s_valid(otr_valid), .s_ready(otr_ready), .s_data(otr_col),
    .s_last(otr_last), .s_void(otr_void),
    .release_i(rel), .done_o(out_done), .n_o(out_n), .ovf_o(ovf_outer),
    .rd_idx(out_idx), .rd_data(out_rd)
  );

  stub_pair_scan #(.ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(DEPTH)) u_scan (
    .clk(clk), .rst_n(rst_n), .win(win_reg),
    .in_done(in_done), .out_done(out_done), .in_n(in_n), .out_n(out_n),
    .in_idx(in_idx), .out_idx(out_idx),
    .in_row(in_rd[IN_W-1:COL_W]), .in_col(in_rd[COL_W-1:0]), .out_col(out_rd),
    .release_o(rel),
    .stub_valid(stub_valid), .stub_ready(stub_ready),
    .stub_row(stub_row), .stub_col(stub_col), .stub_dcol(stub_dcol),
    .cnt_valid(cnt_valid), .cnt_ready(cnt_ready), .cnt_value(cnt_value)
  );

  // R6: no new hits are taken while a crossing's results are pending
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stub_valid || cnt_valid) |-> !inr_ready && !otr_ready)
    else $error("hit input open during result output");
endmodule

// File: tb/stub_finder_bench.sv
module stub_finder_bench;
  localparam int CLK_NS = 10;
  localparam int ROW_W = 8, COL_W = 10, DEPTH = 16;
  localparam int TALLY_W = $clog2(DEPTH * DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic win_we = 0; logic [2:0] win_wdata = 0;
  logic inr_valid = 0, inr_last = 0, inr_void = 0; logic inr_ready;
  logic [ROW_W-1:0] inr_row = 0; logic [COL_W-1:0] inr_col = 0;
  logic otr_valid = 0, otr_last = 0, otr_void = 0; logic otr_ready;
  logic [COL_W-1:0] otr_col = 0;
  logic stub_valid, stub_ready = 0, cnt_valid, cnt_ready = 0;
  logic [ROW_W-1:0] stub_row; logic [COL_W-1:0] stub_col; logic [COL_W:0] stub_dcol;
  logic [TALLY_W-1:0] cnt_value; logic ovf_inner, ovf_outer;

  stub_finder u_stub_finder (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cur_win = 1;
  int ni, no;
  int ic[32], ir[32], oc[32];
  int er[256], ec[256], ed[256]; int ne;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic set_win(int v);
    @(negedge clk); win_we = 1; win_wdata = 3'(v);
    @(negedge clk); win_we = 0; cur_win = v;
  endtask

  task automatic send_inner();
    for (int k = 0; k < (ni == 0 ? 1 : ni); k++) begin
      inr_valid = 1; inr_void = (ni == 0); inr_last = (k == ni - 1) || (ni == 0);
      inr_row = ROW_W'(ir[k]); inr_col = COL_W'(ic[k]);
      while (!inr_ready) @(negedge clk);
      @(posedge clk); @(negedge clk);
    end
    inr_valid = 0; inr_last = 0; inr_void = 0;
  endtask

  task automatic send_outer();
    for (int k = 0; k < (no == 0 ? 1 : no); k++) begin
      otr_valid = 1; otr_void = (no == 0); otr_last = (k == no - 1) || (no == 0);
      otr_col = COL_W'(oc[k]);
      while (!otr_ready) @(negedge clk);
      @(posedge clk); @(negedge clk);
    end
    otr_valid = 0; otr_last = 0; otr_void = 0;
  endtask

  // expected stubs from R2/R3/R4: first 16 per layer, inner-major order
  task automatic build_exp();
    ne = 0;
    for (int i = 0; i < (ni > DEPTH ? DEPTH : ni); i++)
      for (int j = 0; j < (no > DEPTH ? DEPTH : no); j++) begin
        int d = ic[i] - oc[j];
        if ((d < 0 ? -d : d) <= cur_win) begin
          er[ne] = ir[i]; ec[ne] = ic[i]; ed[ne] = d; ne++;
        end
      end
  endtask

  // stall_mode 0: always ready; 1: ready one cycle in three
  task automatic run_xing(string name, int stall_mode);
    int got = 0, cyc = 0; bit fin = 0;
    build_exp();
    fork send_inner(); send_outer(); join
    chk({name, " R6 inner ready low after last"}, int'(inr_ready), 0);
    chk({name, " R6 outer ready low after last"}, int'(otr_ready), 0);
    while (!fin && cyc < 3000) begin
      stub_ready = (stall_mode == 0) || (cyc % 3 == 2);
      cnt_ready  = (stall_mode == 0) || (cyc % 3 == 1);
      if (stub_valid && stub_ready) begin
        if (got < ne) begin
          chk({name, " R4 stub row"}, int'(stub_row), er[got]);
          chk({name, " R4 stub col"}, int'(stub_col), ec[got]);
          chk({name, " R2 stub dcol"}, int'($signed(stub_dcol)), ed[got]);
        end else chk({name, " R2 extra stub"}, got, ne - 1);
        got++;
      end
      if (cnt_valid && cnt_ready) begin
        chk({name, " R5 count value"}, int'(cnt_value), ne);
        chk({name, " R7 stubs received before count"}, got, ne);
        fin = 1;
      end
      @(negedge clk); cyc++;
    end
    stub_ready = 0; cnt_ready = 0;
    chk({name, " R5 count record arrived"}, int'(fin), 1);
    chk({name, " R6 inner ready restored"}, int'(inr_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 inner ready", int'(inr_ready), 1);
    chk("R8 stub valid", int'(stub_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R8 outer ready", int'(otr_ready), 1);
    chk("R8 count valid", int'(cnt_valid), 0);
    chk("R8 overflow flags", int'({ovf_inner, ovf_outer}), 0);

    // R1 default window 1: (10,11) (10,10) (20,19) match; (30,32) not
    ni = 3; ic[0] = 10; ic[1] = 20; ic[2] = 30; ir[0] = 1; ir[1] = 2; ir[2] = 3;
    no = 4; oc[0] = 11; oc[1] = 19; oc[2] = 32; oc[3] = 10;
    run_xing("R1 default window", 0);

    set_win(0);
    run_xing("R2 window zero", 0);

    // R7 window 7 under stalls, large negative diffs, edge columns
    set_win(7);
    ni = 4; ic[0] = 0; ic[1] = 1023; ic[2] = 500; ic[3] = 3;
    ir[0] = 9; ir[1] = 255; ir[2] = 0; ir[3] = 77;
    no = 3; oc[0] = 1023; oc[1] = 7; oc[2] = 493;
    run_xing("R7 wide window stalled", 1);

    // R5 empty outer layer gives zero count
    no = 0;
    run_xing("R5 empty outer", 0);
    ni = 0; no = 2;
    run_xing("R5 empty inner", 1);

    // R3 overflow: 18 inner hits, only first 16 kept
    set_win(1);
    ni = 18;
    for (int k = 0; k < 18; k++) begin ic[k] = 100 + k * 10; ir[k] = k; end
    ic[16] = 50; ic[17] = 51;
    no = 2; oc[0] = 50; oc[1] = 251;
    run_xing("R3 overflow", 0);
    chk("R3 inner overflow set", int'(ovf_inner), 1);
    chk("R3 outer overflow clear", int'(ovf_outer), 0);
    ni = 1; ic[0] = 40; ir[0] = 4; no = 1; oc[0] = 41;
    run_xing("R3 after overflow", 0);
    chk("R3 overflow sticky", int'(ovf_inner), 1);

    finish_run();
  end
endmodule